// File: doc/BRIEF.md
# Addressed Frame Receive Filter

This block sits behind a UART receiver on a half-duplex master/slave serial bus. It reads the incoming byte stream one byte at a time and splits it into frames. Each frame starts with a destination address, followed by a length byte. The length byte counts every byte of the frame, including the address and the length byte. The filter passes on only the payload of frames whose address equals the node's own address. That payload goes out on a valid/ready stream, and the final payload byte of each frame carries a last flag.

Frames sent to other nodes are counted through to their end and then dropped. This includes replies that slaves send to the master at address 0, so a payload byte that happens to equal the node address can never be taken for the start of a frame. A length byte below 2 is malformed. A frame that stalls on the line for too long is abandoned. In both cases the filter goes back to waiting for an address byte. Line time is measured with a one-cycle bit-time strobe supplied from outside.

Top module: `frame_filter`

## Requirements
- R1: While reset is held and after it is released, `pl_valid` is low, and the first byte received after reset is taken as an address byte.
- R2: For a frame whose first byte equals `node_addr` and whose second byte L is 3 or more, the L-2 bytes after the length byte appear on `pl_data` in arrival order. Each one becomes valid on the clock edge that samples it.
- R3: `pl_last` is high with the final payload byte of an accepted frame and low with every other payload byte.
- R4: A frame with any other address, including address 0, is consumed for its full length L and produces no output. The byte that follows it is treated as an address byte.
- R5: A length byte of 0 or 1 produces no output, and the next byte is treated as an address byte.
- R6: A length byte of exactly 2 ends the frame with no output, and the next byte is treated as an address byte.
- R7: After the address byte of a frame, if more than IDLE_BITS bit strobes arrive with no byte between them, the rest of that frame is discarded and the next byte is treated as an address byte. A gap of exactly IDLE_BITS strobes keeps the frame alive.
- R8: While `pl_valid` is high and `pl_ready` is low, `pl_data` and `pl_last` hold steady. A payload byte that arrives in this state is dropped but still counted toward the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_addr | input | DW | Address this node answers to |
| bit_tick | input | 1 | One-cycle strobe, once per bit time on the line |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | DW | Received byte |
| pl_valid | output | 1 | Payload byte available |
| pl_ready | input | 1 | Consumer takes the payload byte |
| pl_data | output | DW | Payload byte |
| pl_last | output | 1 | Final payload byte of the frame |

## Verification
On every cycle the assertions check three things. First, a new payload byte appears only after a byte received in the body of a frame this node has claimed. Second, an offered byte stays frozen under backpressure. Third, a malformed length, a timeout or the final payload byte returns the parser to address hunting. Whether the frame boundaries are right across a sequence of frames can only be shown by the bench scenarios. That covers skipping foreign frames whose payload contains the node address, the length-2 case, the exact gap boundary, and dropped bytes under backpressure that are still counted. The bench checks each of these against a behavioural model.

// File: rtl/frame_filter_pkg.sv
// Shared types for the addressed frame filter.
package frame_filter_pkg;
    // Parser phase: waiting for address, expecting length, inside body.
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEN  = 2'd1,
        ST_BODY = 2'd2
    } ff_state_e;
endpackage

// File: rtl/frame_gap_timer.sv
// Idle-gap watchdog for a frame in progress.
// Counts bit strobes since the last received byte while armed, and
// raises expire on the strobe that would exceed IDLE_BITS.
// Assumes rx_valid and bit_tick are single-cycle strobes.
module frame_gap_timer #(
    parameter int IDLE_BITS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rx_valid,
    input  logic bit_tick,
    output logic expire
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] gap_cnt;

    // A strobe arriving once the count has reached the limit ends the frame.
    assign expire = armed && bit_tick && !rx_valid && (gap_cnt == LIMIT);

    // Count strobes since the last byte; clear on a byte or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || rx_valid) begin
            gap_cnt <= '0;
        end else if (bit_tick && gap_cnt != LIMIT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frame_tracker.sv
// Frame boundary tracker.
// Reads address, then length (whole-frame count), then length-2 body
// bytes. Flags body bytes of frames addressed to this node as emit.
// Assumes one byte per rx_valid strobe and expire never coincides
// with rx_valid.
module frame_tracker
    import frame_filter_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] node_addr,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          expire,
    output ff_state_e     state,
    output logic          hit,
    output logic          emit,
    output logic          emit_last
);
    localparam logic [DW-1:0] HDR_BYTES = DW'(2);

    logic [DW-1:0] remain;

    // A body byte of a claimed frame is forwarded; the final one is marked.
    assign emit      = rx_valid && (state == ST_BODY) && hit;
    assign emit_last = (remain == DW'(1));

    // Phase sequencing, address match latch and body down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            hit    <= 1'b0;
            remain <= '0;
        end else if (rx_valid) begin
            unique case (state)
                ST_HUNT: begin
                    hit   <= (rx_data == node_addr);
                    state <= ST_LEN;
                end
                ST_LEN: begin
                    if (rx_data <= HDR_BYTES) begin
                        state <= ST_HUNT;
                    end else begin
                        remain <= rx_data - HDR_BYTES;
                        state  <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    remain <= remain - 1'b1;
                    if (remain == DW'(1)) state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end else if (expire) begin
            state <= ST_HUNT;
        end
    end
endmodule

// File: rtl/payload_stage.sv
// Single-entry output register for the payload stream.
// Loads a byte when empty or being drained; a byte offered while the
// register is full and stalled is dropped.
module payload_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_last,
    input  logic          pl_ready,
    output logic          pl_valid,
    output logic [DW-1:0] pl_data,
    output logic          pl_last
);
    logic can_take;

    // The register accepts new data only when it is free this cycle.
    assign can_take = !pl_valid || pl_ready;

    // Hold, refill or drain the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_valid <= 1'b0;
            pl_data  <= '0;
            pl_last  <= 1'b0;
        end else if (load && can_take) begin
            pl_valid <= 1'b1;
            pl_data  <= load_data;
            pl_last  <= load_last;
        end else if (pl_ready) begin
            pl_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_filter.sv
// Addressed frame receive filter (top).
// Accepts frames addressed to node_addr from a UART byte stream and
// forwards their payload on a valid/ready stream with a last marker.
// Assumes bit_tick pulses once per bit time on the line.
module frame_filter
    import frame_filter_pkg::*;
#(
    parameter int DW        = 8,
    parameter int IDLE_BITS = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] node_addr,
    input  logic          bit_tick,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          pl_valid,
    input  logic          pl_ready,
    output logic [DW-1:0] pl_data,
    output logic          pl_last
);
    ff_state_e state;
    logic      hit;
    logic      emit;
    logic      emit_last;
    logic      expire;
    logic      armed;

    // The gap timer runs only while a frame is open.
    assign armed = (state != ST_HUNT);

    frame_gap_timer #(.IDLE_BITS(IDLE_BITS)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .rx_valid (rx_valid),
        .bit_tick (bit_tick),
        .expire   (expire)
    );

    frame_tracker #(.DW(DW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .node_addr (node_addr),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .expire    (expire),
        .state     (state),
        .hit       (hit),
        .emit      (emit),
        .emit_last (emit_last)
    );

    payload_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .load_data (rx_data),
        .load_last (emit_last),
        .pl_ready  (pl_ready),
        .pl_valid  (pl_valid),
        .pl_data   (pl_data),
        .pl_last   (pl_last)
    );
endmodule

// File: rtl/frame_filter_chk.sv
// Property checker for frame_filter, bound to every instance.
// Observes ports plus the tracker phase, match latch and timer expiry.
module frame_filter_chk
    import frame_filter_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [DW-1:0] rx_data,
    input logic          pl_valid,
    input logic          pl_ready,
    input logic [DW-1:0] pl_data,
    input logic          pl_last,
    input ff_state_e     state,
    input logic          hit,
    input logic          expire
);
    // R2
    new_byte_from_claimed_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pl_valid) |-> $past(rx_valid && state == ST_BODY && hit));

    // R3
    last_closes_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pl_valid) && pl_last) |-> (state == ST_HUNT));

    // R5
    short_length_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && state == ST_LEN && rx_data < DW'(2)) |=> (state == ST_HUNT));

    // R7
    gap_expiry_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == ST_HUNT));

    // R8
    stalled_output_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_last)));
endmodule

bind frame_filter frame_filter_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .pl_valid (pl_valid),
    .pl_ready (pl_ready),
    .pl_data  (pl_data),
    .pl_last  (pl_last),
    .state    (state),
    .hit      (hit),
    .expire   (expire)
);

// File: tb/frame_filter_test.sv
module frame_filter_test;
    localparam int IDLE = 6;
    localparam logic [7:0] ME = 8'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_v = 1'b0;
    logic [7:0] rx_d = '0;
    logic       rdy = 1'b1;
    logic       pl_valid;
    logic [7:0] pl_data;
    logic       pl_last;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    int  phase = 0;
    int  rem = 0;
    int  gap = 0;
    bit  mine = 0;
    bit  exp_v = 0;
    int  exp_d = 0;
    bit  exp_l = 0;
    int  got_d[$];
    bit  got_l[$];

    always #2 clk = ~clk;

    frame_filter #(.DW(8), .IDLE_BITS(IDLE)) uut (
        .clk (clk), .rst_n (rst_n), .node_addr (ME), .bit_tick (tick),
        .rx_valid (rx_v), .rx_data (rx_d), .pl_valid (pl_valid),
        .pl_ready (rdy), .pl_data (pl_data), .pl_last (pl_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Reference model and consumer capture, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; rem = 0; gap = 0; mine = 0; exp_v = 0; exp_d = 0; exp_l = 0;
        end else begin
            bit em; int ed; bit el;
            if (pl_valid && rdy) begin
                got_d.push_back(pl_data);
                got_l.push_back(pl_last);
            end
            em = rx_v && phase == 2 && mine;
            ed = rx_d;
            el = (rem == 1);
            if (em && (!exp_v || rdy)) begin
                exp_v = 1; exp_d = ed; exp_l = el;
            end else if (rdy) begin
                exp_v = 0;
            end
            if (rx_v) begin
                gap = 0;
                if (phase == 0) begin
                    mine = (rx_d == ME); phase = 1;
                end else if (phase == 1) begin
                    if (rx_d <= 2) phase = 0;
                    else begin rem = rx_d - 2; phase = 2; end
                end else begin
                    rem--;
                    if (rem == 0) phase = 0;
                end
            end else if (phase != 0 && tick) begin
                if (gap == IDLE) begin phase = 0; gap = 0; end
                else gap++;
            end
            if (phase == 0) gap = 0;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(pl_valid == exp_v, cur_req, "pl_valid", pl_valid, exp_v);
            if (exp_v) begin
                chk(pl_data == exp_d[7:0], cur_req, "pl_data", pl_data, exp_d);
                chk(pl_last == exp_l, cur_req, "pl_last", pl_last, exp_l);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_v = 1'b1; rx_d = b;
        @(negedge clk); rx_v = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_got();
        got_d.delete(); got_l.delete();
    endtask

    task automatic expect_got(input string req, input int exp_bytes[$], input int last_idx);
        chk(got_d.size() == exp_bytes.size(), req, "payload count", got_d.size(), exp_bytes.size());
        for (int i = 0; i < exp_bytes.size() && i < got_d.size(); i++) begin
            chk(got_d[i] == exp_bytes[i], req, "payload byte", got_d[i], exp_bytes[i]);
            chk(got_l[i] == (i == last_idx), req, "last flag", got_l[i], (i == last_idx));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: output idle during reset
        chk(pl_valid == 1'b0, "R1", "pl_valid in reset", pl_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pl_valid == 1'b0, "R1", "pl_valid after reset", pl_valid, 0);

        // R1, R2, R3: first byte after reset is an address
        cur_req = "R2";
        clear_got();
        send(ME); send(8'd6); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        settle();
        expect_got("R2", '{8'h11, 8'h22, 8'h33, 8'h44}, 3);

        // R4: foreign frame containing our address, a reply to 0, then ours
        cur_req = "R4";
        clear_got();
        send(8'h07); send(8'd5); send(ME); send(ME); send(ME);
        send(8'h00); send(8'd4); send(ME); send(8'd3);
        send(ME); send(8'd3); send(8'h55);
        settle();
        expect_got("R4", '{8'h55}, 0);

        // R5: length 1 and length 0 are malformed
        cur_req = "R5";
        clear_got();
        send(ME); send(8'd1);
        send(ME); send(8'd0);
        send(ME); send(8'd3); send(8'h66);
        settle();
        expect_got("R5", '{8'h66}, 0);

        // R6: header-only frame
        cur_req = "R6";
        clear_got();
        send(ME); send(8'd2);
        send(ME); send(8'd3); send(8'h77);
        settle();
        expect_got("R6", '{8'h77}, 0);

        // R7: gap above the limit abandons the frame
        cur_req = "R7";
        clear_got();
        send(ME); send(8'd5); send(8'h81);
        ticks(IDLE + 1);
        send(ME); send(8'd3); send(8'h99);
        settle();
        expect_got("R7", '{8'h81, 8'h99}, 1);

        // R7: gap of exactly the limit keeps the frame
        clear_got();
        send(ME); send(8'd4); send(8'hA1);
        ticks(IDLE);
        send(8'hA2);
        settle();
        expect_got("R7", '{8'hA1, 8'hA2}, 1);

        // R8: stalled output holds and drops later bytes, boundary kept
        cur_req = "R8";
        clear_got();
        rdy = 1'b0;
        send(ME); send(8'd5); send(8'hC1); send(8'hC2); send(8'hC3);
        settle();
        chk(pl_valid == 1'b1, "R8", "held valid", pl_valid, 1);
        chk(pl_data == 8'hC1, "R8", "held data", pl_data, 8'hC1);
        rdy = 1'b1;
        send(ME); send(8'd3); send(8'hD1);
        settle();
        expect_got("R8", '{8'hC1, 8'hD1}, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule